// File: doc/BRIEF.md
# Audio bus clock generator

This block produces the two clocks of an audio serial bus when the chip owns them: a bit clock and a word (frame) clock. Both come from one internal reference clock. An integer divider sets the length of a bit period in reference cycles. A frame counter sets how many bit periods make one frame and places the word-clock edges inside it. The word clock can be a one-bit-wide pulse at frame start, or a square wave that is high for the first half of the frame.

Each of the two lines can be master or slave on its own. A master line is driven by the generator and its output enable is high. A slave line is not driven: its output enable is low, and the external clock on that pin is returned on the output so that downstream logic always has one clock to use. When the bit clock is slave and the word clock is master, the frame counter counts rising edges of the external bit clock after a synchronizer.

The generated clocks run while the converter power-up input is high, or while the keep-alive input is high. Starting and stopping happen only on frame boundaries. This means a gating change never produces a partial frame or a short pulse.

Top module: `audclk_gen`

## Requirements
- R1: The bit-clock period is D reference cycles. For a divider setting s from 2 to 127, D = s. Setting 0 gives D = 128. Setting 1 is raised to D = 2.
- R2: Each bit period starts with a rising edge of the bit clock. The clock is high for floor(D/2) reference cycles and low for the rest, so even ratios give 50% duty and odd ratios have the shorter high phase.
- R3: A frame holds N bit periods. N equals the frame-length setting, and settings 0 and 1 are raised to 2.
- R4: With shape input 0 (pulse), the word clock is high for exactly the first bit period of each frame. With shape input 1 (square), it is high for the first floor(N/2) bit periods. With both lines master, every word-clock edge falls in the same reference cycle as a bit-clock rising edge.
- R5: Generated clocks run only while the power-up input or the keep-alive input is high. Otherwise both generated clocks stay low. Keep-alive alone is enough to run them.
- R6: When a run request appears while the generator is idle, a new frame starts. The first bit-clock rising edge and the word-clock rising edge fall in the same reference cycle.
- R7: When the run request is removed mid-frame, the current frame finishes with all N bit periods complete. After that, both clocks stay low and no further frame starts.
- R8: A line whose master select is 0 has output enable low, and its output follows the external clock input for that line. A line whose master select is 1 has output enable high.
- R9: With the bit clock slave and the word clock master, the frame length is counted in rising edges of the external bit clock.
- R10: While reset is asserted, both generated clocks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_sel_i | input | DIV_W (7) | Bit-clock divider setting |
| frame_len_i | input | FLEN_W (9) | Bit periods per frame |
| wclk_shape_i | input | 1 | Word-clock shape: 0 pulse, 1 square |
| bclk_master_i | input | 1 | Bit-clock line is master when 1 |
| wclk_master_i | input | 1 | Word-clock line is master when 1 |
| dac_pwr_i | input | 1 | Converter power-up; requests running clocks |
| keep_alive_i | input | 1 | Keeps clocks running with the converter off |
| bclk_ext_i | input | 1 | External bit clock from the pin |
| wclk_ext_i | input | 1 | External word clock from the pin |
| bclk_o | output | 1 | Bit clock (generated or passed through) |
| bclk_oe_o | output | 1 | Drive enable for the bit-clock pin |
| wclk_o | output | 1 | Word clock (generated or passed through) |
| wclk_oe_o | output | 1 | Drive enable for the word-clock pin |

## Verification
The properties assume that the divider setting, frame length, shape and both master selects are changed only while reset is held. The phase and pulse-width checks compare against those settings and therefore only make sense for static settings. The stimulus follows this rule: every new configuration is applied and then reset is pulsed. The properties also assume that an external bit clock has phases several reference cycles long, so that the synchronizer sees every edge. The bench drives its external bit clock with four-cycle phases. Timing properties are enabled only when the lines concerned are master, because a passed-through clock carries no timing promise from this block.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  // Shape of the generated word clock
  typedef enum logic {
    WCLK_PULSE  = 1'b0,
    WCLK_SQUARE = 1'b1
  } wclk_shape_e;

  // Run control of the frame sequencer
  typedef enum logic {
    RUN_IDLE   = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;

endpackage

// File: rtl/audclk_rst_sync.sv
// Asserts reset asynchronously, releases it on the clock after STAGES edges.
module audclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/audclk_edge_sync.sv
// Brings an asynchronous clock into the reference domain and flags its rising edges.
module audclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] shift_q;
  logic [DEPTH-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[DEPTH-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  // Newest synchronized sample high, one older sample low
  assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];

endmodule

// File: rtl/audclk_bit_div.sv
// Programmable integer divider producing the master bit clock.
module audclk_bit_div #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             run_q_i,
  input  logic             run_nxt_i,
  output logic             tick_o,
  output logic             bclk_o
);

  localparam int              CNT_W     = DIV_W + 1;
  localparam logic [CNT_W-1:0] RATIO_MAX = CNT_W'(1) << DIV_W;
  localparam logic [CNT_W-1:0] RATIO_MIN = CNT_W'(2);

  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;
  logic             cnt_en;

  // Divide ratio: 0 maps to the maximum, 1 is raised to the minimum
  always_comb begin
    if (div_sel_i == '0) begin
      ratio = RATIO_MAX;
    end else if (div_sel_i == DIV_W'(1)) begin
      ratio = RATIO_MIN;
    end else begin
      ratio = {1'b0, div_sel_i};
    end
    half = ratio >> 1;
  end

  // Last reference cycle of the current bit period
  assign tick_o = run_q_i && (cnt_q == (ratio - CNT_W'(1)));
  assign cnt_en = run_q_i | run_nxt_i;

  always_comb begin
    if (!run_nxt_i || !run_q_i || tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    // High phase first, floor(ratio/2) cycles long
    bclk_d = run_nxt_i && (cnt_d < half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk_o = bclk_q;

endmodule

// File: rtl/audclk_frame_ctr.sv
// Frame sequencer: run control gated at frame boundaries, bit index, word clock.
module audclk_frame_ctr
  import audclk_pkg::*;
#(
  parameter int FLEN_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLEN_W-1:0] frame_len_i,
  input  logic              shape_i,
  input  logic              run_req_i,
  input  logic              tick_i,
  output logic              run_q_o,
  output logic              run_nxt_o,
  output logic              wclk_o
);

  localparam logic [FLEN_W-1:0] LEN_MIN = FLEN_W'(2);

  run_state_e        state_q, state_d;
  wclk_shape_e       shape;
  logic [FLEN_W-1:0] len, half_len;
  logic [FLEN_W-1:0] bit_q, bit_d;
  logic              frame_end;
  logic              wclk_q, wclk_d;
  logic              bit_en;

  assign shape = wclk_shape_e'(shape_i);

  always_comb begin
    len      = (frame_len_i < LEN_MIN) ? LEN_MIN : frame_len_i;
    half_len = len >> 1;
  end

  assign frame_end = (state_q == RUN_ACTIVE) && tick_i && (bit_q == (len - FLEN_W'(1)));

  // Start from idle at once; leave the active state only after the last bit
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RUN_IDLE:   if (run_req_i) state_d = RUN_ACTIVE;
      RUN_ACTIVE: if (frame_end && !run_req_i) state_d = RUN_IDLE;
      default:    state_d = RUN_IDLE;
    endcase
  end

  always_comb begin
    if ((state_d == RUN_IDLE) || (state_q == RUN_IDLE)) begin
      bit_d = '0;
    end else if (tick_i) begin
      bit_d = frame_end ? '0 : (bit_q + FLEN_W'(1));
    end else begin
      bit_d = bit_q;
    end
  end

  always_comb begin
    if (state_d != RUN_ACTIVE) begin
      wclk_d = 1'b0;
    end else if (shape == WCLK_SQUARE) begin
      wclk_d = (bit_d < half_len);
    end else begin
      wclk_d = (bit_d == '0);
    end
  end

  assign bit_en = (state_q == RUN_ACTIVE) || (state_d == RUN_ACTIVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RUN_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      wclk_q <= 1'b0;
    end else if (bit_en) begin
      bit_q  <= bit_d;
      wclk_q <= wclk_d;
    end
  end

  assign run_q_o   = (state_q == RUN_ACTIVE);
  assign run_nxt_o = (state_d == RUN_ACTIVE);
  assign wclk_o    = wclk_q;

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int DIV_W       = 7,
  parameter int FLEN_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic [FLEN_W-1:0] frame_len_i,
  input  logic              wclk_shape_i,
  input  logic              bclk_master_i,
  input  logic              wclk_master_i,
  input  logic              dac_pwr_i,
  input  logic              keep_alive_i,
  input  logic              bclk_ext_i,
  input  logic              wclk_ext_i,
  output logic              bclk_o,
  output logic              bclk_oe_o,
  output logic              wclk_o,
  output logic              wclk_oe_o
);

  localparam int LINES  = 2;
  localparam int L_BCLK = 0;
  localparam int L_WCLK = 1;

  logic rst_n_sync;
  logic div_tick;
  logic ext_bclk_rise;
  logic frame_tick;
  logic run_q, run_nxt;
  logic run_req;
  logic bclk_gen, wclk_gen;

  logic [LINES-1:0] line_master;
  logic [LINES-1:0] line_gen;
  logic [LINES-1:0] line_ext;
  logic [LINES-1:0] line_out;

  audclk_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_sync)
  );

  audclk_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_bclk_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .async_i (bclk_ext_i),
    .rise_o  (ext_bclk_rise)
  );

  assign run_req    = dac_pwr_i | keep_alive_i;
  // Frame advances on the own divider or on the synchronized external bit clock
  assign frame_tick = bclk_master_i ? div_tick : ext_bclk_rise;

  audclk_bit_div #(
    .DIV_W (DIV_W)
  ) u_bit_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .div_sel_i (div_sel_i),
    .run_q_i   (run_q),
    .run_nxt_i (run_nxt),
    .tick_o    (div_tick),
    .bclk_o    (bclk_gen)
  );

  audclk_frame_ctr #(
    .FLEN_W (FLEN_W)
  ) u_frame_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .frame_len_i (frame_len_i),
    .shape_i     (wclk_shape_i),
    .run_req_i   (run_req),
    .tick_i      (frame_tick),
    .run_q_o     (run_q),
    .run_nxt_o   (run_nxt),
    .wclk_o      (wclk_gen)
  );

  assign line_master[L_BCLK] = bclk_master_i;
  assign line_master[L_WCLK] = wclk_master_i;
  assign line_gen[L_BCLK]    = bclk_gen;
  assign line_gen[L_WCLK]    = wclk_gen;
  assign line_ext[L_BCLK]    = bclk_ext_i;
  assign line_ext[L_WCLK]    = wclk_ext_i;

  // Per-line master/slave selection
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign line_out[g] = line_master[g] ? line_gen[g] : line_ext[g];
  end

  assign bclk_o    = line_out[L_BCLK];
  assign wclk_o    = line_out[L_WCLK];
  assign bclk_oe_o = line_master[L_BCLK];
  assign wclk_oe_o = line_master[L_WCLK];

endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk #(
  parameter int DIV_W  = 7,
  parameter int FLEN_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DIV_W-1:0]  div_sel_i,
  input logic [FLEN_W-1:0] frame_len_i,
  input logic              wclk_shape_i,
  input logic              bclk_master_i,
  input logic              wclk_master_i,
  input logic              dac_pwr_i,
  input logic              keep_alive_i,
  input logic              bclk_o,
  input logic              wclk_o
);

  logic [15:0] exp_ratio, exp_high, exp_low, exp_len, exp_sq_bits;
  logic [15:0] hi_cnt, lo_cnt;
  logic [15:0] rise_cnt;
  logic        lo_seen;
  logic        b_prev, w_prev;
  logic        both_master;

  always_comb begin
    if (div_sel_i == '0)             exp_ratio = 16'(1 << DIV_W);
    else if (div_sel_i == DIV_W'(1)) exp_ratio = 16'd2;
    else                             exp_ratio = 16'(div_sel_i);
    exp_high    = exp_ratio >> 1;
    exp_low     = exp_ratio - exp_high;
    exp_len     = (frame_len_i < FLEN_W'(2)) ? 16'd2 : 16'(frame_len_i);
    exp_sq_bits = exp_len >> 1;
  end

  assign both_master = bclk_master_i && wclk_master_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      lo_seen  <= 1'b0;
      b_prev   <= 1'b0;
      w_prev   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      b_prev <= bclk_o;
      w_prev <= wclk_o;
      hi_cnt <= bclk_o ? (hi_cnt + 16'd1) : 16'd0;
      if (bclk_o)               lo_cnt <= '0;
      else if (lo_cnt != '1)    lo_cnt <= lo_cnt + 16'd1;
      if (!bclk_o && b_prev)    lo_seen <= 1'b1;
      if (wclk_o && !w_prev)    rise_cnt <= '0;
      else if (bclk_o && !b_prev && rise_cnt != '1) rise_cnt <= rise_cnt + 16'd1;
    end
  end

  // R2
  bclk_high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclk_master_i && $fell(bclk_o)) |-> (hi_cnt == exp_high));

  // R2
  bclk_low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclk_master_i && $rose(bclk_o) && lo_seen) |-> (lo_cnt >= exp_low));

  // R4
  wclk_edge_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_master && ($rose(wclk_o) || $fell(wclk_o))) |-> $rose(bclk_o));

  // R4
  wclk_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_master && !wclk_shape_i && $fell(wclk_o)) |-> (rise_cnt == 16'd0));

  // R4
  wclk_square_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_master && wclk_shape_i && $fell(wclk_o)) |-> (rise_cnt == (exp_sq_bits - 16'd1)));

  // R6
  frame_start_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_master && $rose(wclk_o)) |-> $past(dac_pwr_i || keep_alive_i));

endmodule

bind audclk_gen audclk_gen_chk #(
  .DIV_W  (DIV_W),
  .FLEN_W (FLEN_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .div_sel_i     (div_sel_i),
  .frame_len_i   (frame_len_i),
  .wclk_shape_i  (wclk_shape_i),
  .bclk_master_i (bclk_master_i),
  .wclk_master_i (wclk_master_i),
  .dac_pwr_i     (dac_pwr_i),
  .keep_alive_i  (keep_alive_i),
  .bclk_o        (bclk_o),
  .wclk_o        (wclk_o)
);

// File: tb/audclk_gen_tb_top.sv
`timescale 1ns/1ps
module audclk_gen_tb_top;

  localparam int DIV_W  = 7;
  localparam int FLEN_W = 9;
  localparam int NV     = 7;
  // columns: div setting, frame length, shape, exp high, exp period, exp bits, exp word-high bits
  localparam int VEC [NV][7] = '{
    '{  4,  8, 0,  2,   4,  8,  1},
    '{  5,  6, 1,  2,   5,  6,  3},
    '{  0,  4, 1, 64, 128,  4,  2},
    '{  1,  3, 1,  1,   2,  3,  1},
    '{  7,  0, 0,  3,   7,  2,  1},
    '{127,  5, 1, 63, 127,  5,  2},
    '{  2, 32, 1,  1,   2, 32, 16}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DIV_W-1:0]  div_sel;
  logic [FLEN_W-1:0] frame_len;
  logic              shape, bm, wm, pwr, keep, bext, wext;
  logic              bclk_o, bclk_oe, wclk_o, wclk_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  audclk_gen #(.DIV_W(DIV_W), .FLEN_W(FLEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(div_sel), .frame_len_i(frame_len),
    .wclk_shape_i(shape), .bclk_master_i(bm), .wclk_master_i(wm),
    .dac_pwr_i(pwr), .keep_alive_i(keep), .bclk_ext_i(bext), .wclk_ext_i(wext),
    .bclk_o(bclk_o), .bclk_oe_o(bclk_oe), .wclk_o(wclk_o), .wclk_oe_o(wclk_oe));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_wrise();
    logic pw;
    pw = wclk_o;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (wclk_o && !pw) break;
      pw = wclk_o;
    end
  endtask

  // Measures one frame starting at the next word-clock rise
  task automatic measure(output int hi, output int per, output int bits, output int whi);
    logic pb, pw;
    bit   lo_seen, per_done;
    wait_wrise();
    hi = 1; per = 1; bits = 1; whi = 1;
    lo_seen = 0; per_done = 0;
    pb = bclk_o; pw = wclk_o;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (wclk_o && !pw) break;
      if (bclk_o && !pb) begin
        per_done = 1;
        bits++;
        if (wclk_o) whi++;
      end
      if (!per_done) begin
        per++;
        if (!bclk_o) lo_seen = 1;
        else if (!lo_seen) hi++;
      end
      pb = bclk_o; pw = wclk_o;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, per, bits, whi, highs, brises, wrises;
    logic pb, pw;
    rst_n = 1'b0; div_sel = 7'd4; frame_len = 9'd8; shape = 1'b0;
    bm = 1'b1; wm = 1'b1; pwr = 1'b1; keep = 1'b0; bext = 1'b0; wext = 1'b0;

    // R10: reset state with both lines master and power requested
    repeat (3) @(negedge clk);
    check("R10", "bclk in reset", bclk_o, 0);
    check("R10", "wclk in reset", wclk_o, 0);
    check("R8", "bclk oe master", bclk_oe, 1);
    check("R8", "wclk oe master", wclk_oe, 1);

    // Table of configurations: R1 period, R2 high phase, R3 frame bits, R4 word high
    for (int i = 0; i < NV; i++) begin
      rst_n = 1'b0;
      div_sel = DIV_W'(VEC[i][0]); frame_len = FLEN_W'(VEC[i][1]); shape = (VEC[i][2] != 0);
      pwr = 1'b1; keep = 1'b0;
      pulse_reset();
      measure(hi, per, bits, whi);
      check("R2", $sformatf("vec%0d bclk high", i), hi, VEC[i][3]);
      check("R1", $sformatf("vec%0d bclk period", i), per, VEC[i][4]);
      check("R3", $sformatf("vec%0d frame bits", i), bits, VEC[i][5]);
      check("R4", $sformatf("vec%0d wclk high bits", i), whi, VEC[i][6]);
    end

    // R5: no request, nothing runs
    rst_n = 1'b0; div_sel = 7'd4; frame_len = 9'd6; shape = 1'b0; pwr = 1'b0; keep = 1'b0;
    pulse_reset();
    highs = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (bclk_o || wclk_o) highs++;
    end
    check("R5", "high samples while unrequested", highs, 0);

    // R7: drop power right at frame start; frame must complete, then stop
    pwr = 1'b1;
    wait_wrise();
    pwr = 1'b0;
    highs = 1; brises = 0; wrises = 0;
    pb = bclk_o; pw = wclk_o;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (bclk_o) highs++;
      if (bclk_o && !pb) brises++;
      if (wclk_o && !pw) wrises++;
      pb = bclk_o; pw = wclk_o;
    end
    check("R7", "bclk rises after stop request", brises, 5);
    check("R7", "bclk high cycles in last frame", highs, 12);
    check("R7", "new frames after stop", wrises, 0);
    check("R7", "bclk idle level", bclk_o, 0);
    check("R7", "wclk idle level", wclk_o, 0);

    // R6 and R5: keep-alive alone starts a frame with aligned edges
    keep = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (bclk_o) break;
    end
    check("R6", "bclk at start", bclk_o, 1);
    check("R6", "wclk with first bclk rise", wclk_o, 1);
    measure(hi, per, bits, whi);
    check("R5", "keep-alive frame bits", bits, 6);
    keep = 1'b0;

    // R8: both lines slave, pass-through
    rst_n = 1'b0; bm = 1'b0; wm = 1'b0; pwr = 1'b1;
    pulse_reset();
    bext = 1'b1; wext = 1'b0;
    @(negedge clk);
    check("R8", "bclk pass-through high", bclk_o, 1);
    check("R8", "wclk pass-through low", wclk_o, 0);
    check("R8", "bclk oe slave", bclk_oe, 0);
    check("R8", "wclk oe slave", wclk_oe, 0);
    bext = 1'b0; wext = 1'b1;
    @(negedge clk);
    check("R8", "bclk pass-through low", bclk_o, 0);
    check("R8", "wclk pass-through high", wclk_o, 1);

    // R9: bit clock slave, word clock master, frame counted on external edges
    rst_n = 1'b0; bm = 1'b0; wm = 1'b1; wext = 1'b0; bext = 1'b0;
    frame_len = 9'd4; shape = 1'b0;
    pulse_reset();
    fork
      begin
        for (int k = 0; k < 160; k++) begin
          @(posedge clk); #3;
          bext = ~bext;
          repeat (3) @(posedge clk);
        end
      end
      begin
        measure(hi, per, bits, whi);
      end
    join
    check("R9", "frame bits on external bclk", bits, 4);
    check("R8", "wclk oe with bclk slave", wclk_oe, 1);
    check("R8", "bclk oe with bclk slave", bclk_oe, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule